// File: doc/BRIEF.md
# Coin Vending Controller

This block is the control core of a single-item vending machine that takes two coin sizes, a ₹5 coin and a ₹10 coin. The item costs ₹15. In every clock cycle the controller reads a 2-bit coin code and keeps the credit collected so far in a small state register. When the price is reached, it releases the item. It refunds any overpayment, and it also returns credit that the customer leaves behind.

The dispense and change outputs are combinational in the current state and the coin presented in the same cycle. A purchase or a refund is therefore visible in the cycle in which the coin arrives. The credit register moves on the next rising edge. A cycle with no coin while credit is held counts as abandonment: the held credit is returned at once and the controller goes back to idle. The invalid coin code 2'b11 is handled the same way as a cycle with no coin. An active-high synchronous reset clears any held credit and does not refund it.

Top module: `vend_ctrl`

## Requirements
- R1: An active-high synchronous reset returns the controller to idle with zero credit. In the first cycle after reset is released, a no-coin input (2'b00) gives dispense 0 and change 2'b00, and no credit held before reset is refunded.
- R2: Coin codes are 2'b00 for no coin, 2'b01 for ₹5 and 2'b10 for ₹10. When idle, a no-coin cycle drives all outputs to zero and keeps the controller idle. A ₹5 coin stores ₹5 of credit and a ₹10 coin stores ₹10 of credit, and neither produces any output in that cycle.
- R3: With ₹5 held and no coin, change is 2'b01 (₹5 returned) and dispense is 0 in that cycle, and the controller is idle afterwards.
- R4: With ₹5 held, a ₹10 coin gives dispense 1 and change 2'b00 in that cycle, and the controller is idle afterwards.
- R5: With ₹5 held, a ₹5 coin produces no output and raises the held credit to ₹10.
- R6: With ₹10 held, a ₹5 coin gives dispense 1 and change 2'b00, and the controller is idle afterwards.
- R7: With ₹10 held, a ₹10 coin gives dispense 1 and change 2'b01 (₹5 excess returned), and the controller is idle afterwards.
- R8: With ₹10 held and no coin, change is 2'b10 (₹10 returned) and dispense is 0, and the controller is idle afterwards.
- R9: The coin code 2'b11 is invalid and acts exactly like no coin. It never dispenses, and it refunds the held credit with change 2'b00, 2'b01 or 2'b10 for ₹0, ₹5 or ₹10 held.
- R10: Dispense is high for exactly one cycle per purchase: the controller is idle in the cycle after any dispense. The change output never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 2 | Coin code: 00 none, 01 ₹5, 10 ₹10, 11 invalid |
| dispense_o | output | 1 | High in the cycle an item is released |
| change_o | output | 2 | Refund code: 00 none, 01 ₹5, 10 ₹10 |

## Verification
The assertions assume that `coin_i` is a clean, settled code for each clock cycle. Each code value stands for exactly one coin event per cycle, so a coin held over several cycles counts as several coins. The bench changes the coin only on the falling edge, holds each code for a single cycle, and draws codes from all four values, including the invalid 2'b11. It also weights the draws towards no-coin cycles so that abandonment refunds appear often among the purchases.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int COIN_W      = 2;
  localparam int SUM_W       = COIN_W + 1;
  localparam int PRICE_UNITS = 3;

  typedef enum logic [COIN_W-1:0] {
    ST_IDLE = 2'b00,
    ST_FIVE = 2'b01,
    ST_TEN  = 2'b10,
    ST_BAD  = 2'b11
  } vend_state_e;

  // A valid coin code equals its value in ₹5 units.
  function automatic logic [COIN_W-1:0] coin_units(input logic [COIN_W-1:0] code);
    case (code)
      2'b01:   coin_units = 2'd1;
      2'b10:   coin_units = 2'd2;
      default: coin_units = 2'd0;
    endcase
  endfunction

  function automatic logic coin_valid(input logic [COIN_W-1:0] code);
    coin_valid = (code == 2'b01) || (code == 2'b10);
  endfunction

  function automatic logic [COIN_W-1:0] held_units(input vend_state_e st);
    case (st)
      ST_FIVE: held_units = 2'd1;
      ST_TEN:  held_units = 2'd2;
      default: held_units = 2'd0;
    endcase
  endfunction

  function automatic vend_state_e units_to_state(input logic [SUM_W-1:0] units);
    case (units)
      3'd1:    units_to_state = ST_FIVE;
      3'd2:    units_to_state = ST_TEN;
      default: units_to_state = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/vend_credit_step.sv
module vend_credit_step
  import vend_pkg::*;
(
  input  vend_state_e        state_i,
  input  logic [COIN_W-1:0]  coin_i,
  output vend_state_e        next_o,
  output logic               dispense_o,
  output logic [COIN_W-1:0]  change_o,
  output logic               purchase_o,
  output logic               refund_o
);

  logic [SUM_W-1:0] held_w;
  logic [SUM_W-1:0] paid_w;
  logic [SUM_W-1:0] total_w;
  logic             ok_w;

  assign held_w  = SUM_W'(held_units(state_i));
  assign paid_w  = SUM_W'(coin_units(coin_i));
  assign total_w = held_w + paid_w;
  assign ok_w    = coin_valid(coin_i);

  always_comb begin
    next_o     = ST_IDLE;
    dispense_o = 1'b0;
    change_o   = '0;
    if (state_i == ST_BAD) begin
      next_o = ST_IDLE;
    end else if (!ok_w) begin
      change_o = COIN_W'(held_w);
      next_o   = ST_IDLE;
    end else if (total_w >= SUM_W'(PRICE_UNITS)) begin
      dispense_o = 1'b1;
      change_o   = COIN_W'(total_w - SUM_W'(PRICE_UNITS));
      next_o     = ST_IDLE;
    end else begin
      next_o = units_to_state(total_w);
    end
  end

  assign purchase_o = dispense_o;
  assign refund_o   = (change_o != '0);

endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  vend_state_e next_i,
  output vend_state_e state_o
);

  always_ff @(posedge clk) begin
    if (rst) state_o <= ST_IDLE;
    else     state_o <= next_i;
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COIN_W-1:0] coin_i,
  output logic              dispense_o,
  output logic [COIN_W-1:0] change_o
);

  vend_state_e state_q;
  vend_state_e state_d;
  logic        purchase_evt;
  logic        refund_evt;

  vend_credit_step step_i (
    .state_i    (state_q),
    .coin_i     (coin_i),
    .next_o     (state_d),
    .dispense_o (dispense_o),
    .change_o   (change_o),
    .purchase_o (purchase_evt),
    .refund_o   (refund_evt)
  );

  vend_state_reg reg_i (
    .clk     (clk),
    .rst     (rst),
    .next_i  (state_d),
    .state_o (state_q)
  );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [COIN_W-1:0] coin_i,
  input logic              dispense_o,
  input logic [COIN_W-1:0] change_o,
  input vend_state_e       state_q,
  input logic              purchase_evt,
  input logic              refund_evt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && coin_i == 2'b00) |-> (!dispense_o && change_o == 2'b00));

  // R2
  idle_five_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && coin_i == 2'b01) |=> state_q == ST_FIVE);

  // R2
  idle_ten_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && coin_i == 2'b10) |=> state_q == ST_TEN);

  // R3
  five_abandon_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIVE && coin_i == 2'b00) |-> (change_o == 2'b01 && !purchase_evt));

  // R4
  five_buy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIVE && coin_i == 2'b10) |-> (dispense_o && !refund_evt));

  // R5
  five_add_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIVE && coin_i == 2'b01) |=> state_q == ST_TEN);

  // R6
  ten_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEN && coin_i == 2'b01) |-> (dispense_o && change_o == 2'b00));

  // R7
  ten_over_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEN && coin_i == 2'b10) |-> (dispense_o && change_o == 2'b01));

  // R8
  ten_abandon_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEN && coin_i == 2'b00) |-> (change_o == 2'b10 && !dispense_o));

  // R9
  bad_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_i == 2'b11) |-> (!dispense_o && change_o == COIN_W'(held_units(state_q))));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dispense_o |=> (state_q == ST_IDLE));

  // R10
  change_code_chk: assert property (@(posedge clk) disable iff (rst)
    change_o != 2'b11);

  // R10
  bad_state_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BAD) |=> (state_q == ST_IDLE));

endmodule

bind vend_ctrl vend_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .coin_i       (coin_i),
  .dispense_o   (dispense_o),
  .change_o     (change_o),
  .state_q      (state_q),
  .purchase_evt (purchase_evt),
  .refund_evt   (refund_evt)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin = 2'b00;
  logic       dispense;
  logic [1:0] change;

  int checks = 0;
  int errors = 0;
  int credit = 0;   // rupees held by the reference model
  bit done = 0;

  always #2.5 clk = ~clk;

  vend_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .coin_i     (coin),
    .dispense_o (dispense),
    .change_o   (change)
  );

  function automatic int coin_value(input logic [1:0] c);
    if (c == 2'b01) return 5;
    if (c == 2'b10) return 10;
    return 0;
  endfunction

  function automatic logic [1:0] rupees_code(input int r);
    if (r == 5)  return 2'b01;
    if (r == 10) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_of(input int held, input logic [1:0] c);
    if (c == 2'b11) return "R9";
    if (held == 0)  return "R2";
    if (held == 5)  return (c == 2'b00) ? "R3" : (c == 2'b10) ? "R4" : "R5";
    return (c == 2'b00) ? "R8" : (c == 2'b01) ? "R6" : "R7";
  endfunction

  task automatic check(input string tag, input logic ad, input logic [1:0] ac,
                       input logic ed, input logic [1:0] ec);
    checks++;
    if (ad !== ed || ac !== ec) begin
      errors++;
      $display("FAIL %s: dispense=%b change=%b expected dispense=%b change=%b",
               tag, ad, ac, ed, ec);
    end
  endtask

  // One coin cycle: drive on the falling edge, compare before the rising edge.
  task automatic step(input logic [1:0] c);
    logic       ed;
    logic [1:0] ec;
    int         total;
    string      tag;
    @(negedge clk);
    coin = c;
    #1;
    tag = tag_of(credit, c);
    total = credit + coin_value(c);
    ed = 1'b0;
    ec = 2'b00;
    if (coin_value(c) == 0) begin
      ec = rupees_code(credit);
      credit = 0;
    end else if (total >= 15) begin
      ed = 1'b1;
      ec = rupees_code(total - 15);
      credit = 0;
    end else begin
      credit = total;
    end
    check(tag, dispense, change, ed, ec);
    // R10: a dispense leaves the controller idle, so an idle cycle then gives nothing
    if (ed) begin
      @(negedge clk);
      coin = 2'b00;
      #1;
      check("R10", dispense, change, 1'b0, 2'b00);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    coin = 2'b00;
    @(negedge clk);
    rst = 1'b0;
    credit = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1;
    check("R1", dispense, change, 1'b0, 2'b00);

    // R2 / R3
    step(2'b01); step(2'b00);
    // R4
    step(2'b01); step(2'b10);
    // R5 then R6
    step(2'b01); step(2'b01); step(2'b01);
    // R7
    step(2'b10); step(2'b10);
    // R8
    step(2'b10); step(2'b00);
    // R9 in each credit level
    step(2'b11);
    step(2'b01); step(2'b11);
    step(2'b10); step(2'b11);
    // R2: idle stays idle
    step(2'b00); step(2'b00);

    // R1: credit held before reset is dropped without refund
    step(2'b10);
    do_reset();
    step(2'b00);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3)      step(2'b00);
      else if (r < 6) step(2'b01);
      else if (r < 9) step(2'b10);
      else            step(2'b11);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule